// File: doc/BRIEF.md
# Multi-Plane Page Address Sequencer

This block turns one streaming transfer request into the ordered list of flash block/page addresses that a transfer engine must visit. A request carries a starting block, a starting page, a total page count and a plane-count code. The block first checks the request: the start block must be aligned to the plane count, the page count must be a non-zero multiple of the plane count, and the pages visited in each plane must stay inside one block. A request that fails any check raises a one-cycle error flag, and no addresses are produced.

For a valid request the sequencer sweeps across the planes. The page is held while the block steps up by one per plane. After the last plane of a sweep, the page advances by one and the block returns to the starting block. With a single plane this gives consecutive pages inside one block. Reads and writes use the same ordering, so the block has no direction input.

Addresses are offered with a valid/ready handshake. Each address is held until it is accepted. After the final acceptance a one-cycle done pulse is raised and the sequencer goes back to idle.

Top module: `mp_addr_seq`

## Requirements
- R1: After reset, addr_valid, done, err and busy are all low.
- R2: plane_sel selects the plane count: 0 gives 1 plane, 1 gives 2 planes, 2 gives 4 planes. The value 3 is rejected as an error.
- R3: A start_blk that is not a multiple of the plane count is rejected as an error.
- R4: A page_cnt of zero, or one that is not a multiple of the plane count, is rejected as an error.
- R5: If start_pg plus page_cnt divided by the plane count exceeds 2^PG_W, the pages would cross a block boundary, and the request is rejected as an error.
- R6: A rejected request raises err for exactly the one cycle after start is sampled. No address is offered and busy stays low.
- R7: For an accepted request, addr_valid rises in the cycle after start is sampled, with addr_blk = start_blk and addr_pg = start_pg.
- R8: Within one sweep, each accepted address is followed by one with the same page and the block one higher.
- R9: After the last plane of a sweep is accepted, the next address has the page one higher and the block equal to start_blk.
- R10: While addr_valid is high and addr_ready is low, addr_valid, addr_blk and addr_pg hold their values.
- R11: Exactly page_cnt addresses are offered. In the cycle after the last one is accepted, done is high for one cycle, addr_valid is low and busy is low.
- R12: A start pulse while busy is ignored. The running sequence continues unchanged.
- R13: With one plane, the addresses are start_pg, start_pg+1, and so on, all in start_blk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled only when idle |
| start_blk | input | BLK_W | Starting block address |
| start_pg | input | PG_W | Starting page address |
| page_cnt | input | CNT_W | Total page count across all planes |
| plane_sel | input | 2 | Plane-count code (0:1, 1:2, 2:4, 3:invalid) |
| addr_ready | input | 1 | Transfer engine accepts the offered address |
| addr_valid | output | 1 | An address is offered |
| addr_blk | output | BLK_W | Offered block address |
| addr_pg | output | PG_W | Offered page address |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after the last address is accepted |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
A wrong plane index or base register shows up at the ports on the very next accepted address. The block would fail to step or fail to return to start_blk, so each acceptance is compared with a computed block/page pair. A wrong remaining count shows up as done arriving early or late against the exact page_cnt. Each check rule is exercised at its edge, both just inside and just outside it, and the err pulse and absence of addr_valid are observed in the following cycle.

// File: rtl/mp_seq_pkg.sv
package mp_seq_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  function automatic logic [2:0] plane_count(input logic [1:0] sel);
    case (sel)
      2'd0:    plane_count = 3'd1;
      2'd1:    plane_count = 3'd2;
      2'd2:    plane_count = 3'd4;
      default: plane_count = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/mp_req_check.sv
module mp_req_check
  import mp_seq_pkg::*;
#(
  parameter int BLK_W = 10,
  parameter int PG_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic [BLK_W-1:0] blk,
  input  logic [PG_W-1:0]  pg,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       psel,
  output logic             ok
);
  localparam int SW = CNT_W + PG_W + 1;
  localparam logic [SW-1:0] PG_LIMIT = SW'(1) << PG_W;

  logic [2:0]    np;
  logic [1:0]    low_mask;
  logic [SW-1:0] span;
  logic          sel_ok, cnt_ok, align_ok, span_ok;

  always_comb begin
    np       = plane_count(psel);
    low_mask = 2'(np - 3'd1);
    span     = SW'(pg) + SW'(cnt >> psel);
    sel_ok   = (psel != 2'd3);
    cnt_ok   = (cnt != '0) && ((cnt[1:0] & low_mask) == 2'd0);
    align_ok = ((blk[1:0] & low_mask) == 2'd0);
    span_ok  = (span <= PG_LIMIT);
    ok       = sel_ok && cnt_ok && align_ok && span_ok;
  end
endmodule

// File: rtl/mp_addr_step.sv
module mp_addr_step
  import mp_seq_pkg::*;
#(
  parameter int BLK_W = 10,
  parameter int PG_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [BLK_W-1:0] blk_in,
  input  logic [PG_W-1:0]  pg_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [1:0]       psel_in,
  output logic [BLK_W-1:0] cur_blk,
  output logic [PG_W-1:0]  cur_pg,
  output logic             last
);
  logic [BLK_W-1:0] base_blk;
  logic [CNT_W-1:0] remaining;
  logic [1:0]       plane_idx;
  logic [1:0]       psel_q;
  logic [1:0]       last_idx;
  logic             sweep_end;

  always_comb begin
    last_idx  = 2'(plane_count(psel_q) - 3'd1);
    sweep_end = (plane_idx == last_idx);
    last      = (remaining == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_blk  <= '0;
      cur_blk   <= '0;
      cur_pg    <= '0;
      remaining <= '0;
      plane_idx <= '0;
      psel_q    <= '0;
    end else if (load) begin
      base_blk  <= blk_in;
      cur_blk   <= blk_in;
      cur_pg    <= pg_in;
      remaining <= cnt_in;
      plane_idx <= '0;
      psel_q    <= psel_in;
    end else if (adv) begin
      remaining <= remaining - CNT_W'(1);
      if (sweep_end) begin
        plane_idx <= '0;
        cur_blk   <= base_blk;
        cur_pg    <= cur_pg + PG_W'(1);
      end else begin
        plane_idx <= plane_idx + 2'd1;
        cur_blk   <= cur_blk + BLK_W'(1);
      end
    end
  end

  // R8
  in_sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && !sweep_end) |=> (cur_pg == $past(cur_pg)) &&
                                     (cur_blk == BLK_W'($past(cur_blk) + BLK_W'(1))));
  // R9
  sweep_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && sweep_end) |=> (cur_blk == base_blk) &&
                                    (cur_pg == PG_W'($past(cur_pg) + PG_W'(1))));
endmodule

// File: rtl/mp_addr_seq.sv
module mp_addr_seq
  import mp_seq_pkg::*;
#(
  parameter int BLK_W = 10,
  parameter int PG_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] start_blk,
  input  logic [PG_W-1:0]  start_pg,
  input  logic [CNT_W-1:0] page_cnt,
  input  logic [1:0]       plane_sel,
  input  logic             addr_ready,
  output logic             addr_valid,
  output logic [BLK_W-1:0] addr_blk,
  output logic [PG_W-1:0]  addr_pg,
  output logic             busy,
  output logic             done,
  output logic             err
);
  seq_state_e state;
  logic req_ok, load, take, last;

  mp_req_check #(.BLK_W(BLK_W), .PG_W(PG_W), .CNT_W(CNT_W)) u_check (
    .blk(start_blk), .pg(start_pg), .cnt(page_cnt), .psel(plane_sel), .ok(req_ok)
  );

  always_comb begin
    load = start && (state == ST_IDLE) && req_ok;
    take = addr_valid && addr_ready;
  end

  mp_addr_step #(.BLK_W(BLK_W), .PG_W(PG_W), .CNT_W(CNT_W)) u_step (
    .clk(clk), .rst(rst), .load(load), .adv(take),
    .blk_in(start_blk), .pg_in(start_pg), .cnt_in(page_cnt), .psel_in(plane_sel),
    .cur_blk(addr_blk), .cur_pg(addr_pg), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      addr_valid <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= start && (state == ST_IDLE) && !req_ok;
      if (load) begin
        state      <= ST_RUN;
        addr_valid <= 1'b1;
      end else if (take && last) begin
        state      <= ST_IDLE;
        addr_valid <= 1'b0;
        done       <= 1'b1;
      end
    end
  end

  assign busy = (state == ST_RUN);

  // R10
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready) |=> addr_valid && $stable(addr_blk) && $stable(addr_pg));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !addr_valid && !busy);
  // R6
  err_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !addr_valid && !busy && !done);
  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !$past(start)) |-> 1'b0);
endmodule

// File: tb/test_mp_addr_seq.sv
module test_mp_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 10;
  localparam int PG_W  = 6;
  localparam int CNT_W = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [BLK_W-1:0] start_blk = '0;
  logic [PG_W-1:0]  start_pg = '0;
  logic [CNT_W-1:0] page_cnt = '0;
  logic [1:0]       plane_sel = '0;
  logic addr_ready = 1'b0;
  logic addr_valid, busy, done, err;
  logic [BLK_W-1:0] addr_blk;
  logic [PG_W-1:0]  addr_pg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_addr_seq #(.BLK_W(BLK_W), .PG_W(PG_W), .CNT_W(CNT_W)) i_mp_addr_seq (
    .clk(clk), .rst(rst), .start(start), .start_blk(start_blk), .start_pg(start_pg),
    .page_cnt(page_cnt), .plane_sel(plane_sel), .addr_ready(addr_ready),
    .addr_valid(addr_valid), .addr_blk(addr_blk), .addr_pg(addr_pg),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int blk, input int pg, input int cnt, input int ps);
    start_blk = BLK_W'(blk); start_pg = PG_W'(pg);
    page_cnt = CNT_W'(cnt); plane_sel = 2'(ps);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Runs one sequence; stall cycles before the first accept, with a
  // stray start pulse during the stall when poke is set.
  task automatic run_seq(input int blk, input int pg, input int cnt, input int ps,
                         input int stall, input bit poke, input string req);
    int np;
    np = 1 << ps;
    issue(blk, pg, cnt, ps);
    chk(addr_valid == 1'b1 && busy == 1'b1, "R7 valid after start", addr_valid, 1);
    for (int k = 0; k < cnt; k++) begin
      int eb, ep;
      eb = blk + (k % np);
      ep = pg + (k / np);
      if (k == 0) begin
        for (int s = 0; s < stall; s++) begin
          if (poke && s == 0) begin
            start_blk = BLK_W'(blk + 100); start_pg = '0;
            page_cnt = CNT_W'(1); plane_sel = 2'd0; start = 1'b1;
          end
          @(negedge clk);
          start = 1'b0;
          chk(addr_valid && addr_blk == BLK_W'(eb) && addr_pg == PG_W'(ep),
              poke ? "R12 stray start ignored" : "R10 hold under stall", addr_blk, eb);
        end
      end
      chk(addr_valid == 1'b1, req, addr_valid, 1);
      chk(addr_blk == BLK_W'(eb), req, addr_blk, eb);
      chk(addr_pg == PG_W'(ep), req, addr_pg, ep);
      chk(done == 1'b0, "R11 no early done", done, 0);
      addr_ready = 1'b1;
      @(negedge clk);
      addr_ready = 1'b0;
    end
    chk(done == 1'b1, "R11 done after last", done, 1);
    chk(addr_valid == 1'b0 && busy == 1'b0, "R11 idle after last", addr_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
  endtask

  task automatic reject(input int blk, input int pg, input int cnt, input int ps,
                        input string req);
    issue(blk, pg, cnt, ps);
    chk(err == 1'b1, req, err, 1);
    chk(addr_valid == 1'b0 && busy == 1'b0, "R6 no address on error", addr_valid, 0);
    @(negedge clk);
    chk(err == 1'b0, "R6 err one cycle", err, 0);
    chk(addr_valid == 1'b0 && busy == 1'b0, "R6 stays idle", busy, 0);
  endtask

  task automatic test_reset();
    chk(addr_valid == 1'b0, "R1 reset valid", addr_valid, 0);
    chk(done == 1'b0 && err == 1'b0, "R1 reset flags", done, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_seq(5, 10, 4, 0, 0, 0, "R13 single plane");
    run_seq(8, 3, 6, 1, 0, 0, "R8 R9 two planes");
    run_seq(12, 0, 8, 2, 0, 0, "R2 R8 R9 four planes");
    run_seq(4, 20, 8, 2, 3, 0, "R10 stalled run");
    run_seq(16, 1, 4, 1, 2, 1, "R12 run with stray start");
    run_seq(0, 62, 4, 1, 0, 0, "R5 fits at block end");
    reject(4, 0, 4, 3, "R2 code 3 rejected");
    reject(6, 0, 8, 2, "R3 misaligned for four");
    reject(3, 0, 4, 1, "R3 misaligned for two");
    reject(4, 0, 6, 2, "R4 count not multiple");
    reject(4, 0, 0, 0, "R4 zero count");
    reject(0, 63, 4, 1, "R5 crosses block end");
    run_seq(20, 0, 2, 1, 0, 0, "R7 run after errors");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule